// File: doc/BRIEF.md
# Physical Memory Attribute Lookup Unit

This unit tells the core what kind of memory a physical address points at: Device, Non-Cacheable or Cacheable. It also says whether the address lies in memory that secure software shares with non-secure software. Two sources supply the answer. The first is a small bank of programmable regions, each held as a base register and a mask register. The second is a set of regions fixed when the block is built, grouped by type, and each one can be switched on or off through an enable bitmap for its type.

The lookup port is purely combinational. An address presented on `lk_addr` yields its attribute, share flag and no-match flag in the same cycle. Software reaches the registers through a simple register write/read port. The registers it can write are the base and mask of every programmable region and the three enable bitmaps. The bitmaps accept writes only in machine mode. Each mask is checked for the aligned power-of-two shape, and any region whose mask breaks that shape is flagged on a status vector.

Register map on `csr_addr` (5 bits): addresses 0..NUM_RGN-1 hold the region base registers. Addresses 8..8+NUM_RGN-1 hold the region mask registers. Address 16 is the Device fixed-region bitmap, 17 the Non-Cacheable bitmap and 18 the Cacheable bitmap. The block supports at most 8 programmable regions.

Top module: `pma_lookup`

## Requirements
- R1: Base register control bits: bit 0 enables the region, bit 2 selects Non-Cacheable, and bit 1 selects Device when bit 2 is clear. With both bits 1 and 2 clear the region is Cacheable. An enabled region matches an address when (address AND mask) equals (base AND mask). `lk_attr` encodes 2'b00 Device, 2'b01 Non-Cacheable, 2'b10 Cacheable, and never takes 2'b11.
- R2: A region whose base bit 0 is 0 never matches, whatever its type bits.
- R3: When several enabled regions match, whether programmable or fixed, the result is Non-Cacheable if any of them is Non-Cacheable. Otherwise it is Cacheable if any is Cacheable, and Device otherwise.
- R4: An address matched by no enabled region gives `lk_attr` = Device, `lk_share` = 0 and `lk_miss` = 1. `lk_miss` is 0 whenever some region matches.
- R5: The low 12 bits of every mask register are stored and read back as zero, whatever value is written.
- R6: A mask write clears bit 0 of the same region's base register, which then reads back as 0. The region stays inactive until a later base write sets bit 0.
- R7: `mask_bad[r]` is 1 exactly when the stored mask of region r is not a run of ones from the top bit followed only by zeros. A non-conforming mask is still stored.
- R8: Fixed region i of a type covers a 2^SHIFT-byte window starting at the type's base plus i·2^SHIFT. The defaults are: Device at 0xF000_0000 with 64KB windows, Non-Cacheable at 0xE000_0000 with 64KB windows, and Cacheable at 0x8000_0000 with 16MB windows, with NUM_FIX = 4 regions per type. A fixed region takes part only while bit i of its type's bitmap is 1. Bitmap bits at index NUM_FIX and above read as 0 and ignore writes.
- R9: Bitmap writes take effect only when `priv_mode` is 2'b11 (machine mode). Writes from any other mode leave the bitmaps unchanged.
- R10: `lk_share` is 1 when some matching enabled programmable region has base bit 3 set. Fixed regions never set it.
- R11: After reset every base, mask and bitmap register reads 0. Every lookup then misses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| priv_mode | input | 2 | Current privilege level, 2'b11 = machine |
| csr_we | input | 1 | Register write strobe |
| csr_addr | input | 5 | Register select for write and read |
| csr_wdata | input | AW | Register write data |
| csr_rdata | output | AW | Read data for `csr_addr` (combinational) |
| lk_addr | input | AW | Physical address to classify |
| lk_attr | output | 2 | Resolved attribute |
| lk_share | output | 1 | Secure-share flag |
| lk_miss | output | 1 | No enabled region matched |
| mask_bad | output | NUM_RGN | Per-region malformed-mask flag |

## Verification
Several properties are checked on every cycle: a miss always reports Device with no share, any Non-Cacheable hit forces the Non-Cacheable result, and the attribute code stays legal. Two register behaviours are also checked each cycle: a mask write always leaves its region disabled on the next cycle, and writes from below machine mode never move the bitmaps. Other behaviours come to light only in the bench scenarios, which compare against a behavioural model each cycle. These cover the exact ranges that fixed and programmable windows claim, the forced-zero mask bits, malformed-mask flagging and the read-only high bitmap bits. They also cover the full ordering among overlapping regions, including Cacheable winning over Device.

// File: rtl/pma_pkg.sv
// Shared types and constants for the attribute lookup unit.
// Assumes a 5-bit register select and at most 8 slots per register group.
package pma_pkg;
    typedef enum logic [1:0] {
        ATTR_DEV = 2'b00,
        ATTR_NC  = 2'b01,
        ATTR_CA  = 2'b10
    } attr_e;

    localparam int CSR_AW    = 5;
    localparam int FIX_SLOTS = 8;
    localparam int GRAN_BITS = 12;
    localparam logic [CSR_AW-1:0] SEL_DEV_EN = 5'h10;
    localparam logic [CSR_AW-1:0] SEL_NC_EN  = 5'h11;
    localparam logic [CSR_AW-1:0] SEL_CA_EN  = 5'h12;
    localparam logic [1:0] PRIV_M = 2'b11;
endpackage

// File: rtl/pma_prog_bank.sv
// Programmable region bank: per region a base and a mask register, the
// match against the lookup address, and type/share hit vectors.
// Assumes NUM_RGN <= 8 and AW > 12; base at select r, mask at select 8+r.
module pma_prog_bank
    import pma_pkg::*;
#(
    parameter int NUM_RGN = 8,
    parameter int AW      = 32
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            csr_we,
    input  logic [CSR_AW-1:0]               csr_addr,
    input  logic [AW-1:0]                   csr_wdata,
    input  logic [AW-1:0]                   lk_addr,
    output logic [NUM_RGN-1:0][AW-1:0]      base_rd,
    output logic [NUM_RGN-1:0][AW-1:0]      mask_rd,
    output logic [NUM_RGN-1:0]              rgn_en,
    output logic [NUM_RGN-1:0]              hit_nc,
    output logic [NUM_RGN-1:0]              hit_ca,
    output logic [NUM_RGN-1:0]              hit_dev,
    output logic [NUM_RGN-1:0]              hit_share,
    output logic [NUM_RGN-1:0]              mask_bad
);
    localparam int UW = AW - GRAN_BITS;

    for (genvar g = 0; g < NUM_RGN; g++) begin : g_rgn
        logic [AW-1:0] base_q;
        logic [UW-1:0] mask_hi_q;
        logic [UW-1:0] inv_hi;
        logic          wr_base;
        logic          wr_mask;
        logic          match;

        assign wr_base = csr_we && (csr_addr == CSR_AW'(g));
        assign wr_mask = csr_we && (csr_addr == CSR_AW'(FIX_SLOTS + g));

        // Base register: full write, or enable cleared by a mask write.
        always_ff @(posedge clk) begin
            if (!rst_n)       base_q    <= '0;
            else if (wr_base) base_q    <= csr_wdata;
            else if (wr_mask) base_q[0] <= 1'b0;
        end

        // Mask register: only bits above the 4KB granule are kept.
        always_ff @(posedge clk) begin
            if (!rst_n)       mask_hi_q <= '0;
            else if (wr_mask) mask_hi_q <= csr_wdata[AW-1:GRAN_BITS];
        end

        // Compare address and base on the bits the mask keeps.
        always_comb begin
            match = ((lk_addr[AW-1:GRAN_BITS] ^ base_q[AW-1:GRAN_BITS]) & mask_hi_q) == '0;
        end

        // Shape check: inverted mask must be of the form 0..01..1.
        assign inv_hi      = ~mask_hi_q;
        assign mask_bad[g] = |(inv_hi & (inv_hi + 1'b1));

        assign base_rd[g]   = base_q;
        assign mask_rd[g]   = {mask_hi_q, {GRAN_BITS{1'b0}}};
        assign rgn_en[g]    = base_q[0];
        assign hit_nc[g]    = base_q[0] && match && base_q[2];
        assign hit_dev[g]   = base_q[0] && match && !base_q[2] && base_q[1];
        assign hit_ca[g]    = base_q[0] && match && !base_q[2] && !base_q[1];
        assign hit_share[g] = base_q[0] && match && base_q[3];
    end
endmodule

// File: rtl/pma_fixed_set.sv
// One type's group of build-time regions: region i spans 2^SHIFT bytes
// from BASE + i*2^SHIFT and counts only while its enable bit is set.
// Assumes NUM_FIX <= 8 and BASE aligned to 2^SHIFT.
module pma_fixed_set
    import pma_pkg::*;
#(
    parameter int            AW      = 32,
    parameter int            NUM_FIX = 4,
    parameter logic [AW-1:0] BASE    = '0,
    parameter int            SHIFT   = 16
) (
    input  logic [AW-1:0]        lk_addr,
    input  logic [FIX_SLOTS-1:0] en,
    output logic                 hit
);
    logic [NUM_FIX-1:0] hits;

    for (genvar i = 0; i < NUM_FIX; i++) begin : g_fix
        localparam logic [AW-1:0] RBASE = BASE + (AW'(i) << SHIFT);
        assign hits[i] = en[i] && ((lk_addr >> SHIFT) == (RBASE >> SHIFT));
    end

    assign hit = |hits;
endmodule

// File: rtl/pma_resolve.sv
// Type priority: Non-Cacheable over Cacheable over Device; no hit gives
// Device with the miss flag raised. Purely combinational.
module pma_resolve
    import pma_pkg::*;
(
    input  logic  any_nc,
    input  logic  any_ca,
    input  logic  any_dev,
    input  logic  any_share,
    output attr_e attr,
    output logic  share,
    output logic  miss
);
    // Pick the winning type in fixed priority order.
    always_comb begin
        if (any_nc)      attr = ATTR_NC;
        else if (any_ca) attr = ATTR_CA;
        else             attr = ATTR_DEV;
    end

    assign miss  = !(any_nc || any_ca || any_dev);
    assign share = any_share && !miss;
endmodule

// File: rtl/pma_lookup.sv
// Top of the attribute lookup unit: register port, machine-mode-only
// fixed-region enable bitmaps, programmable bank, fixed groups and
// priority resolution. Assumes NUM_RGN <= 8 and NUM_FIX <= 8.
module pma_lookup
    import pma_pkg::*;
#(
    parameter int            NUM_RGN   = 8,
    parameter int            AW        = 32,
    parameter int            NUM_FIX   = 4,
    parameter logic [AW-1:0] DEV_BASE  = 32'hF000_0000,
    parameter int            DEV_SHIFT = 16,
    parameter logic [AW-1:0] NC_BASE   = 32'hE000_0000,
    parameter int            NC_SHIFT  = 16,
    parameter logic [AW-1:0] CA_BASE   = 32'h8000_0000,
    parameter int            CA_SHIFT  = 24
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [1:0]         priv_mode,
    input  logic               csr_we,
    input  logic [4:0]         csr_addr,
    input  logic [AW-1:0]      csr_wdata,
    output logic [AW-1:0]      csr_rdata,
    input  logic [AW-1:0]      lk_addr,
    output logic [1:0]         lk_attr,
    output logic               lk_share,
    output logic               lk_miss,
    output logic [NUM_RGN-1:0] mask_bad
);
    localparam logic [FIX_SLOTS-1:0] FIX_KEEP = FIX_SLOTS'((1 << NUM_FIX) - 1);

    logic [FIX_SLOTS-1:0]       dev_en_q, nc_en_q, ca_en_q;
    logic [NUM_RGN-1:0][AW-1:0] base_rd, mask_rd;
    logic [NUM_RGN-1:0]         rgn_en, p_nc, p_ca, p_dev, p_share;
    logic                       f_nc, f_ca, f_dev;
    logic                       any_nc, any_ca, any_dev, any_share;
    logic                       bm_wr;
    attr_e                      attr;

    assign bm_wr = csr_we && (priv_mode == PRIV_M);

    // Fixed-region enable bitmaps, machine mode only, absent bits held at 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dev_en_q <= '0;
            nc_en_q  <= '0;
            ca_en_q  <= '0;
        end else if (bm_wr) begin
            if (csr_addr == SEL_DEV_EN) dev_en_q <= csr_wdata[FIX_SLOTS-1:0] & FIX_KEEP;
            if (csr_addr == SEL_NC_EN)  nc_en_q  <= csr_wdata[FIX_SLOTS-1:0] & FIX_KEEP;
            if (csr_addr == SEL_CA_EN)  ca_en_q  <= csr_wdata[FIX_SLOTS-1:0] & FIX_KEEP;
        end
    end

    pma_prog_bank #(.NUM_RGN(NUM_RGN), .AW(AW)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .csr_we    (csr_we),
        .csr_addr  (csr_addr),
        .csr_wdata (csr_wdata),
        .lk_addr   (lk_addr),
        .base_rd   (base_rd),
        .mask_rd   (mask_rd),
        .rgn_en    (rgn_en),
        .hit_nc    (p_nc),
        .hit_ca    (p_ca),
        .hit_dev   (p_dev),
        .hit_share (p_share),
        .mask_bad  (mask_bad)
    );

    pma_fixed_set #(.AW(AW), .NUM_FIX(NUM_FIX), .BASE(DEV_BASE), .SHIFT(DEV_SHIFT)) u_fix_dev (
        .lk_addr (lk_addr), .en (dev_en_q), .hit (f_dev)
    );
    pma_fixed_set #(.AW(AW), .NUM_FIX(NUM_FIX), .BASE(NC_BASE), .SHIFT(NC_SHIFT)) u_fix_nc (
        .lk_addr (lk_addr), .en (nc_en_q), .hit (f_nc)
    );
    pma_fixed_set #(.AW(AW), .NUM_FIX(NUM_FIX), .BASE(CA_BASE), .SHIFT(CA_SHIFT)) u_fix_ca (
        .lk_addr (lk_addr), .en (ca_en_q), .hit (f_ca)
    );

    assign any_nc    = (|p_nc)  || f_nc;
    assign any_ca    = (|p_ca)  || f_ca;
    assign any_dev   = (|p_dev) || f_dev;
    assign any_share = |p_share;

    pma_resolve u_res (
        .any_nc    (any_nc),
        .any_ca    (any_ca),
        .any_dev   (any_dev),
        .any_share (any_share),
        .attr      (attr),
        .share     (lk_share),
        .miss      (lk_miss)
    );
    assign lk_attr = attr;

    // Read multiplexer over bases, masks and bitmaps; unmapped reads 0.
    always_comb begin
        csr_rdata = '0;
        for (int r = 0; r < NUM_RGN; r++) begin
            if (csr_addr == CSR_AW'(r))             csr_rdata = base_rd[r];
            if (csr_addr == CSR_AW'(FIX_SLOTS + r)) csr_rdata = mask_rd[r];
        end
        if (csr_addr == SEL_DEV_EN) csr_rdata = {{(AW-FIX_SLOTS){1'b0}}, dev_en_q};
        if (csr_addr == SEL_NC_EN)  csr_rdata = {{(AW-FIX_SLOTS){1'b0}}, nc_en_q};
        if (csr_addr == SEL_CA_EN)  csr_rdata = {{(AW-FIX_SLOTS){1'b0}}, ca_en_q};
    end
endmodule

// File: rtl/pma_lookup_chk.sv
// Checker for pma_lookup: cross-cycle and cross-module properties of the
// lookup result and the register state. Attached by bind below.
module pma_lookup_chk #(
    parameter int NUM_RGN = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic [1:0]         priv_mode,
    input logic               csr_we,
    input logic [4:0]         csr_addr,
    input logic [7:0]         dev_en_q,
    input logic [7:0]         nc_en_q,
    input logic [7:0]         ca_en_q,
    input logic [NUM_RGN-1:0] rgn_en,
    input logic               any_nc,
    input logic [1:0]         lk_attr,
    input logic               lk_share,
    input logic               lk_miss
);
    a_r4_miss_gives_dev: assert property (@(posedge clk) disable iff (!rst_n)
        lk_miss |-> (lk_attr == 2'b00) && !lk_share);

    a_r3_nc_wins: assert property (@(posedge clk) disable iff (!rst_n)
        any_nc |-> (lk_attr == 2'b01));

    a_r1_attr_legal: assert property (@(posedge clk) disable iff (!rst_n)
        lk_attr != 2'b11);

    a_r9_bitmap_priv: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_we && priv_mode != 2'b11) |=> $stable({dev_en_q, nc_en_q, ca_en_q}));

    a_r6_mask_disables: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_we && csr_addr[4:3] == 2'b01 && 32'(csr_addr[2:0]) < NUM_RGN)
        |=> !((rgn_en >> $past(csr_addr[2:0])) & 1'b1));
endmodule

bind pma_lookup pma_lookup_chk #(.NUM_RGN(NUM_RGN)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .priv_mode (priv_mode),
    .csr_we    (csr_we),
    .csr_addr  (csr_addr),
    .dev_en_q  (dev_en_q),
    .nc_en_q   (nc_en_q),
    .ca_en_q   (ca_en_q),
    .rgn_en    (rgn_en),
    .any_nc    (any_nc),
    .lk_attr   (lk_attr),
    .lk_share  (lk_share),
    .lk_miss   (lk_miss)
);

// File: tb/pma_lookup_bench.sv
// Bench: behavioural reference model, compared against the design every cycle.
module pma_lookup_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [1:0]  priv;
    logic        we;
    logic [4:0]  addr;
    logic [31:0] wdata;
    logic [31:0] rdata;
    logic [31:0] lka;
    logic [1:0]  attr;
    logic        share, miss;
    logic [7:0]  bad;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    string phase = "R11";

    always #5 clk = ~clk;

    pma_lookup u_pma_lookup (
        .clk (clk), .rst_n (rst_n), .priv_mode (priv), .csr_we (we),
        .csr_addr (addr), .csr_wdata (wdata), .csr_rdata (rdata),
        .lk_addr (lka), .lk_attr (attr), .lk_share (share), .lk_miss (miss),
        .mask_bad (bad)
    );

    // Reference state
    logic [31:0] m_base [8];
    logic [31:0] m_mask [8];
    logic [7:0]  m_en   [3];

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < 8; r++) begin m_base[r] = '0; m_mask[r] = '0; end
            for (int t = 0; t < 3; t++) m_en[t] = '0;
        end else if (we) begin
            if (addr < 5'd8) m_base[addr[2:0]] = wdata;
            else if (addr < 5'd16) begin
                m_mask[addr[2:0]]    = wdata & 32'hFFFF_F000;
                m_base[addr[2:0]][0] = 1'b0;
            end else if (addr <= 5'd18 && priv == 2'b11)
                m_en[int'(addr) - 16] = wdata[7:0] & 8'h0F;
        end
    end

    function automatic logic [3:0] exp_look(logic [31:0] a);
        bit nc = 0, ca = 0, dv = 0, sh = 0;
        logic [1:0] at;
        for (int r = 0; r < 8; r++)
            if (m_base[r][0] && ((a & m_mask[r]) == (m_base[r] & m_mask[r]))) begin
                if (m_base[r][2]) nc = 1;
                else if (m_base[r][1]) dv = 1;
                else ca = 1;
                if (m_base[r][3]) sh = 1;
            end
        for (int i = 0; i < 4; i++) begin
            if (m_en[0][i] && a[31:16] == 16'hF000 + 16'(i)) dv = 1;
            if (m_en[1][i] && a[31:16] == 16'hE000 + 16'(i)) nc = 1;
            if (m_en[2][i] && a[31:24] == 8'h80 + 8'(i))     ca = 1;
        end
        at = nc ? 2'b01 : (ca ? 2'b10 : 2'b00);
        return {at, sh, !(nc || ca || dv)};
    endfunction

    function automatic logic [31:0] exp_rd(logic [4:0] s);
        if (s < 5'd8)   return m_base[s[2:0]];
        if (s < 5'd16)  return m_mask[s[2:0]];
        if (s <= 5'd18) return {24'b0, m_en[int'(s) - 16]};
        return '0;
    endfunction

    function automatic logic [7:0] exp_bad();
        logic [7:0] v = '0;
        for (int r = 0; r < 8; r++) begin
            bit seen0 = 0;
            for (int b = 31; b >= 12; b--) begin
                if (!m_mask[r][b]) seen0 = 1;
                else if (seen0) v[r] = 1'b1;
            end
        end
        return v;
    endfunction

    // One cycle: drive at the falling edge, then compare everything.
    task automatic step(input bit w, input logic [4:0] s, input logic [31:0] d,
                        input logic [31:0] la, input string ph);
        logic [43:0] got, exp;
        @(negedge clk);
        we = w; addr = s; wdata = d; lka = la; phase = ph;
        #2;
        got = {attr, share, miss, rdata, bad};
        exp = {exp_look(la), exp_rd(s), exp_bad()};
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: attr/share/miss/rdata/bad got %h expected %h", ph, got, exp);
        end
    endtask

    task automatic wr(input logic [4:0] s, input logic [31:0] d, input string ph);
        step(1'b1, s, d, 32'h0000_1000, ph);
    endtask

    task automatic look(input logic [4:0] s, input logic [31:0] la, input string ph);
        step(1'b0, s, 32'h0, la, ph);
    endtask

    initial begin
        rst_n = 1'b0; priv = 2'b11; we = 1'b0; addr = '0; wdata = '0; lka = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R11 reset state, R4 miss
        for (int s = 0; s < 19; s++) look(5'(s), 32'h2000_0000, "R11");
        look(5'd0, 32'hF000_0000, "R4");
        // R5 forced-zero mask bits, R1 cacheable region
        wr(5'd8, 32'hFFFF_0FFF, "R5");
        look(5'd8, 32'h2000_1234, "R5");
        wr(5'd0, 32'h2000_0001, "R1");
        look(5'd0, 32'h2000_1234, "R1");
        look(5'd0, 32'h2001_0000, "R4");
        // R3 NC inside CA
        wr(5'd9, 32'hFFFF_F000, "R3");
        wr(5'd1, 32'h2000_3005, "R3");
        look(5'd1, 32'h2000_3ABC, "R3");
        look(5'd1, 32'h2000_4000, "R3");
        // R10 share from a Device region spanning both
        wr(5'd10, 32'hFF00_0000, "R10");
        wr(5'd2, 32'h2000_000B, "R10");
        look(5'd2, 32'h2000_3000, "R10");
        look(5'd2, 32'h2100_0000, "R10");
        look(5'd2, 32'h2000_5000, "R10");
        // R2 disabled NC region never matches
        wr(5'd11, 32'hF000_0000, "R2");
        wr(5'd3, 32'h3000_0004, "R2");
        look(5'd3, 32'h3000_0000, "R2");
        // R6 mask write disables the region until base is rewritten
        wr(5'd8, 32'hFFFF_0000, "R6");
        look(5'd0, 32'h2000_1234, "R6");
        wr(5'd0, 32'h2000_0001, "R6");
        look(5'd0, 32'h2000_1234, "R6");
        // R7 malformed mask flag
        wr(5'd12, 32'hF0F0_0000, "R7");
        look(5'd12, 32'h0, "R7");
        wr(5'd12, 32'hFFF0_0000, "R7");
        look(5'd12, 32'h0, "R7");
        // R8 fixed Device group, absent bits
        wr(5'd16, 32'h0000_00FF, "R8");
        look(5'd16, 32'hF001_0000, "R8");
        look(5'd16, 32'hF004_0000, "R8");
        // R9 write from supervisor ignored
        priv = 2'b01;
        wr(5'd17, 32'h0000_000F, "R9");
        look(5'd17, 32'hE000_0000, "R9");
        priv = 2'b11;
        wr(5'd17, 32'h0000_0002, "R8");
        look(5'd17, 32'hE001_0000, "R8");
        look(5'd17, 32'hE000_0000, "R8");
        wr(5'd18, 32'h0000_0001, "R8");
        look(5'd18, 32'h80FF_FFFF, "R8");
        // R3 fixed CA beats programmable Device
        wr(5'd13, 32'hFF00_0000, "R3");
        wr(5'd5, 32'h8000_0003, "R3");
        look(5'd5, 32'h8000_1000, "R3");
        look(5'd5, 32'h8100_0000, "R3");
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog in %s: got timeout expected completion", phase);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule